// File: doc/BRIEF.md
# Half-Bridge Driver Serial Control Port

This block is the serial slave port of a controller for three half-bridge power stages. A host drives chip select (active low), a serial clock and a data line. All three are oversampled by the system clock through synchronizers. While a command word shifts in, the port shifts out a status word that it snapshots when chip select falls. When chip select rises, the port checks the frame. The command reaches the control register only if the number of serial clock rising edges is a nonzero multiple of the word width and the serial clock is low at that moment. An accepted frame raises a one-cycle strobe, publishes the captured word, drives the six driver-enable outputs and the three protection-mode outputs, and raises a status-reset strobe when the command asks for one.

Several ports can be chained, with the data output of one feeding the data input of the next. The first word out of each port is its own status. After that, the output repeats the input delayed by one word. Each port keeps the last word it received, so one long frame loads every port in the chain.

Top module: `hb_spi_port`

## Requirements
- R1: After reset the output enable is low, the driver enables, mode outputs, command word and both strobes are all zero.
- R2: The serial output enable is low while the synchronized chip select is high and high while it is low; the data output is 0 whenever the enable is low.
- R3: A few system clocks after chip select falls, and before any serial clock edge, the serial output shows the thermal-warning input.
- R4: The status word goes out least significant bit first, with one new bit after each serial clock falling edge. Its layout is: bit 15 supply fail, bit 14 under-load, bit 13 overcurrent, bit 12 shoot-through attempt, bits 11..7 zero, bits 6..1 the current driver enables, bit 0 thermal warning.
- R5: Input data is sampled on serial clock rising edges, least significant bit first. An accepted command maps bit 15 to `ovlo_en`, bit 14 to `uld_shdn_en`, bit 13 to `oc_fast` and bits 6..1 to `drv_en[5:0]`. In `drv_en`, bit 0 is the low side of bridge 1, bit 1 its high side, bits 2 and 3 bridge 2, and bits 4 and 5 bridge 3.
- R6: A frame whose rising-edge count is not a multiple of 16 (for example 15 or 17) is discarded: no strobe, outputs unchanged.
- R7: A frame with no serial clock edge at all is discarded.
- R8: A frame that ends with the serial clock high is discarded.
- R9: In a 32-bit frame the last 16 bits received become the command. The second 16 bits shifted out equal the first 16 bits received.
- R10: Each accepted frame gives exactly one `frm_valid` pulse, with `cmd_word` updated in the same cycle. `sts_clr` pulses with it only when command bit 0 is 1. Otherwise `cmd_word` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| flt_supply | input | 1 | Sticky supply-fail flag |
| flt_underload | input | 1 | Sticky under-load flag |
| flt_overcur | input | 1 | Sticky overcurrent flag |
| flt_shoot | input | 1 | Sticky shoot-through attempt flag |
| flt_therm | input | 1 | Sticky thermal-warning flag |
| drv_en | output | 6 | Driver enables, low/high side per bridge |
| ovlo_en | output | 1 | Overvoltage lockout mode |
| uld_shdn_en | output | 1 | Under-load shutdown mode |
| oc_fast | output | 1 | Short overcurrent delay select |
| sts_clr | output | 1 | One-cycle status-reset strobe |
| frm_valid | output | 1 | One-cycle accepted-frame strobe |
| cmd_word | output | 16 | Last accepted command word |

## Verification
The bench sends frames of 15 and 17 bits. A port that latched on every chip-select rise, or on any count of 16 or more, would change its drivers on those frames. It also sends a frame that ends with the clock high and a frame with no clock at all; a port that skipped either check would accept them. A 32-bit chained frame checks that the first word is passed through and the last word is kept. A design with the shift direction or the pass-through wrong would load the first word or return corrupted data. The thermal bit is checked before any clock edge, where a port that loaded status only on the first edge would show a stale value.

// File: rtl/hb_spi_pkg.sv
package hb_spi_pkg;
   localparam int SRR_POS = 0;
   localparam int DRV_LSB = 1;

   typedef struct packed {
      logic supply_fail;
      logic under_load;
      logic over_cur;
      logic shoot_thru;
      logic therm_warn;
   } hb_flt_t;
endpackage

// File: rtl/hb_spi_sync.sv
module hb_spi_sync #(
   parameter int           WIDTH   = 1,
   parameter int           STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hb_spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_spi_shift.sv
module hb_spi_shift #(
   parameter int WORD_W         = 16,
   parameter bit CHECK_SCLK_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_q,
   input  logic              sclk_q,
   input  logic              mosi_q,
   input  logic [WORD_W-1:0] status_word,
   output logic              miso,
   output logic              miso_oe,
   output logic              frame_ok,
   output logic [WORD_W-1:0] frame_word
);
   localparam int              CNT_W    = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   logic              cs_d, sclk_d, active, seen, smp;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] sr;
   logic              cs_fall, cs_rise, sclk_rise, sclk_fall, sclk_ok;

   assign cs_fall   = cs_d & ~cs_q;
   assign cs_rise   = ~cs_d & cs_q;
   assign sclk_rise = ~sclk_d & sclk_q & ~cs_q & active;
   assign sclk_fall = sclk_d & ~sclk_q & ~cs_q & active & seen;

   generate
      if (CHECK_SCLK_LOW) begin : g_sclk_chk
         assign sclk_ok = ~sclk_q;
      end else begin : g_sclk_free
         assign sclk_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
         active <= 1'b0;
         seen   <= 1'b0;
         smp    <= 1'b0;
         cnt    <= '0;
         sr     <= '0;
      end else begin
         cs_d   <= cs_q;
         sclk_d <= sclk_q;
         if (cs_fall) begin
            active <= 1'b1;
            seen   <= 1'b0;
            cnt    <= '0;
            sr     <= status_word;
         end else if (cs_rise) begin
            active <= 1'b0;
            seen   <= 1'b0;
            cnt    <= '0;
         end else begin
            if (sclk_rise) begin
               smp  <= mosi_q;
               seen <= 1'b1;
               cnt  <= (cnt == CNT_LAST) ? '0 : cnt + CNT_W'(1);
            end
            if (sclk_fall) sr <= {smp, sr[WORD_W-1:1]};
         end
      end
   end

   assign frame_ok   = cs_rise & active & seen & (cnt == '0) & sclk_ok;
   assign frame_word = sr;
   assign miso       = active & sr[0];
   assign miso_oe    = active;
endmodule

// File: rtl/hb_spi_ctrl.sv
module hb_spi_ctrl #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_ok,
   input  logic [WORD_W-1:0] frame_word,
   output logic [WORD_W-1:0] cmd_q,
   output logic              valid_q,
   output logic              clr_q
);
   import hb_spi_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         valid_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         valid_q <= frame_ok;
         clr_q   <= frame_ok & frame_word[SRR_POS];
         if (frame_ok) cmd_q <= frame_word;
      end
   end
endmodule

// File: rtl/hb_spi_port.sv
module hb_spi_port #(
   parameter int WORD_W         = 16,
   parameter int N_BRIDGE       = 3,
   parameter int SYNC_STAGES    = 2,
   parameter bit CHECK_SCLK_LOW = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spi_cs_n,
   input  logic                  spi_sclk,
   input  logic                  spi_mosi,
   output logic                  spi_miso,
   output logic                  spi_miso_oe,
   input  logic                  flt_supply,
   input  logic                  flt_underload,
   input  logic                  flt_overcur,
   input  logic                  flt_shoot,
   input  logic                  flt_therm,
   output logic [2*N_BRIDGE-1:0] drv_en,
   output logic                  ovlo_en,
   output logic                  uld_shdn_en,
   output logic                  oc_fast,
   output logic                  sts_clr,
   output logic                  frm_valid,
   output logic [WORD_W-1:0]     cmd_word
);
   import hb_spi_pkg::*;

   localparam int DRV_N    = 2 * N_BRIDGE;
   localparam int DRV_MSB  = DRV_LSB + DRV_N - 1;
   localparam int POS_OVLO = WORD_W - 1;
   localparam int POS_ULD  = WORD_W - 2;
   localparam int POS_OC   = WORD_W - 3;
   localparam int POS_STA  = WORD_W - 4;

   generate
      if (POS_STA <= DRV_MSB) begin : g_bad_width
         $error("hb_spi_port: WORD_W too small for the driver field");
      end
   endgenerate

   logic              cs_q, sclk_q, mosi_q;
   logic [WORD_W-1:0] status_word, frame_word, cmd_q;
   logic              frame_ok;
   hb_flt_t           flt;

   hb_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     ({cs_q, sclk_q, mosi_q})
   );

   assign flt = '{supply_fail: flt_supply, under_load: flt_underload,
                  over_cur: flt_overcur, shoot_thru: flt_shoot,
                  therm_warn: flt_therm};

   always_comb begin
      status_word                  = '0;
      status_word[POS_OVLO]        = flt.supply_fail;
      status_word[POS_ULD]         = flt.under_load;
      status_word[POS_OC]          = flt.over_cur;
      status_word[POS_STA]         = flt.shoot_thru;
      status_word[DRV_MSB:DRV_LSB] = cmd_q[DRV_MSB:DRV_LSB];
      status_word[0]               = flt.therm_warn;
   end

   hb_spi_shift #(.WORD_W(WORD_W), .CHECK_SCLK_LOW(CHECK_SCLK_LOW)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_q        (cs_q),
      .sclk_q      (sclk_q),
      .mosi_q      (mosi_q),
      .status_word (status_word),
      .miso        (spi_miso),
      .miso_oe     (spi_miso_oe),
      .frame_ok    (frame_ok),
      .frame_word  (frame_word)
   );

   hb_spi_ctrl #(.WORD_W(WORD_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_ok   (frame_ok),
      .frame_word (frame_word),
      .cmd_q      (cmd_q),
      .valid_q    (frm_valid),
      .clr_q      (sts_clr)
   );

   assign cmd_word    = cmd_q;
   assign drv_en      = cmd_q[DRV_MSB:DRV_LSB];
   assign ovlo_en     = cmd_q[POS_OVLO];
   assign uld_shdn_en = cmd_q[POS_ULD];
   assign oc_fast     = cmd_q[POS_OC];
endmodule

// File: rtl/hb_spi_port_chk.sv
module hb_spi_port_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_q,
   input logic              spi_miso,
   input logic              spi_miso_oe,
   input logic              flt_therm,
   input logic              frm_valid,
   input logic              sts_clr,
   input logic [WORD_W-1:0] cmd_word
);
   AST_OE_DROPS_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_q) |=> !spi_miso_oe); // R2

   AST_QUIET_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_miso_oe |-> !spi_miso); // R2

   AST_THERM_AT_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_q) |=> (spi_miso_oe && (spi_miso == $past(flt_therm)))); // R3

   AST_CMD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_word != $past(cmd_word)) |-> frm_valid); // R10

   AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid); // R10

   AST_CLR_NEEDS_SRR: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr |-> (frm_valid && cmd_word[0])); // R10

   AST_VALID_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> !spi_miso_oe); // R6
endmodule

bind hb_spi_port hb_spi_port_chk #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_q        (cs_q),
   .spi_miso    (spi_miso),
   .spi_miso_oe (spi_miso_oe),
   .flt_therm   (flt_therm),
   .frm_valid   (frm_valid),
   .sts_clr     (sts_clr),
   .cmd_word    (cmd_word)
);

// File: tb/hb_spi_port_bench.sv
module hb_spi_port_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic f_sup = 0, f_uld = 0, f_oc = 0, f_sta = 0, f_tw = 0;
   logic miso, miso_oe, ovlo, uld, ocf, clr, fv;
   logic [5:0]  drv;
   logic [15:0] cmd;
   int n_chk = 0, n_bad = 0, n_frm = 0, n_clr = 0;

   always #2.5 clk = ~clk;

   hb_spi_port u_hb_spi_port (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe),
      .flt_supply(f_sup), .flt_underload(f_uld), .flt_overcur(f_oc),
      .flt_shoot(f_sta), .flt_therm(f_tw),
      .drv_en(drv), .ovlo_en(ovlo), .uld_shdn_en(uld), .oc_fast(ocf),
      .sts_clr(clr), .frm_valid(fv), .cmd_word(cmd)
   );

   always @(posedge clk) begin
      if (rst_n && fv)  n_frm++;
      if (rst_n && clr) n_clr++;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input int nbits, input logic [63:0] din, input bit end_high,
                       output logic [63:0] dout);
      dout = '0;
      cs_n = 1'b0;
      wait_clk(8);
      for (int i = 0; i < nbits; i++) begin
         mosi = din[i];
         wait_clk(8);
         dout[i] = miso;
         sclk = 1'b1;
         wait_clk(8);
         if (!(end_high && i == nbits - 1)) sclk = 1'b0;
      end
      wait_clk(8);
      cs_n = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      mosi = 1'b0;
      wait_clk(8);
   endtask

   task automatic t_reset;
      chk("R1 oe", miso_oe, 0);
      chk("R1 drv", drv, 0);
      chk("R1 modes", {ovlo, uld, ocf}, 0);
      chk("R1 cmd", cmd, 0);
      chk("R1 strobes", {fv, clr}, 0);
   endtask

   task automatic t_idle;
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b1; wait_clk(6);
         chk("R2 idle oe", miso_oe, 0);
         sclk = 1'b0; wait_clk(6);
      end
   endtask

   task automatic t_therm;
      int f0 = n_frm;
      f_tw = 1'b1;
      cs_n = 1'b0; wait_clk(8);
      chk("R2 oe while selected", miso_oe, 1);
      chk("R3 warning set", miso, 1);
      cs_n = 1'b1; wait_clk(8);
      f_tw = 1'b0;
      cs_n = 1'b0; wait_clk(8);
      chk("R3 warning clear", miso, 0);
      cs_n = 1'b1; wait_clk(10);
      chk("R7 no-clock frame", n_frm - f0, 0);
      chk("R2 oe off", miso_oe, 0);
   endtask

   task automatic t_basic;
      logic [63:0] so;
      int f0 = n_frm, c0 = n_clr;
      f_sup = 1; f_uld = 0; f_oc = 1; f_sta = 1; f_tw = 0;
      xfer(16, 64'hA04A, 0, so);
      f_sup = 0; f_oc = 0; f_sta = 0;
      chk("R4 status word", so[15:0], 16'hB000);
      chk("R5 drivers", drv, 6'b100101);
      chk("R5 modes", {ovlo, uld, ocf}, 3'b101);
      chk("R10 one pulse", n_frm - f0, 1);
      chk("R10 no clear", n_clr - c0, 0);
      chk("R10 cmd word", cmd, 16'hA04A);
   endtask

   task automatic t_srr;
      logic [63:0] so;
      int c0 = n_clr;
      f_tw = 1;
      xfer(16, 64'h4013, 0, so);
      f_tw = 0;
      chk("R4 echo and warning", so[15:0], 16'h004B);
      chk("R10 clear strobe", n_clr - c0, 1);
      chk("R5 drivers", drv, 6'b001001);
      chk("R5 modes", {ovlo, uld, ocf}, 3'b010);
   endtask

   task automatic t_badlen;
      logic [63:0] so;
      int f0 = n_frm;
      xfer(15, 64'hFFFF, 0, so);
      chk("R6 15 bits drivers", drv, 6'b001001);
      xfer(17, 64'h1FFFF, 0, so);
      chk("R6 17 bits drivers", drv, 6'b001001);
      chk("R6 no pulse", n_frm - f0, 0);
   endtask

   task automatic t_sclk_high;
      logic [63:0] so;
      int f0 = n_frm;
      xfer(16, 64'hE07E, 1, so);
      chk("R8 drivers", drv, 6'b001001);
      chk("R8 no pulse", n_frm - f0, 0);
   endtask

   task automatic t_daisy;
      logic [63:0] so;
      int f0 = n_frm;
      xfer(32, {32'h0, 16'h8006, 16'h1234}, 0, so);
      chk("R4 status first", so[15:0], 16'h0012);
      chk("R9 pass-through", so[31:16], 16'h1234);
      chk("R9 last word kept", cmd, 16'h8006);
      chk("R9 drivers", drv, 6'b000011);
      chk("R9 one pulse", n_frm - f0, 1);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_idle();
      t_therm();
      t_basic();
      t_srr();
      t_badlen();
      t_sclk_high();
      t_daisy();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule